// File: doc/BRIEF.md
# Descriptor-Fetching Block Transfer DMA Channel

This block is one DMA channel that serves single or block transfers. The control record for each transfer lives in ordinary memory as three words. After software enables the channel, every transfer request makes the channel ask for the system bus. Once the bus is granted, the channel fetches the three-word record. It then copies up to one block of data units from a source pointer to a destination pointer. At the end it stores the updated count and pointers back into the record and returns the bus.

The record's first word packs four fields: the remaining unit count in bits [15:0], the block length in bits [23:16], the source pointer mode in bits [25:24] and the destination pointer mode in bits [27:26]. The second word is the source address and the third is the destination address. These words sit at `desc_base`, `desc_base+1` and `desc_base+2`. Memory is word-addressed, and a read returns its data in the cycle after it is issued. When the count reaches zero, the channel switches itself off. If the interrupt enable is set at that point, it also raises a sticky interrupt.

Top module: `dma_blk_seq`

## Requirements
- R1: After reset `bus_req`, `mem_en`, `irq` and `ch_on` are 0. A `xfer_req` pulse while `ch_on` is 0 is dropped and produces no bus request.
- R2: A request latched while the channel is on raises `bus_req`. No memory access is made while `bus_gnt` is 0 in that wait.
- R3: After the grant the channel reads the three record words from `desc_base`, `desc_base+1` and `desc_base+2`, in that order, as its first three bus accesses.
- R4: Each request moves min(block length, count) units, where a block length of 0 moves one unit. Each unit is one read at the source pointer followed by one write of that data at the destination pointer.
- R5: `xfer_ack` is high for exactly the cycle of each data write. `xfer_end` is high together with it on the write that brings the count to zero, and at no other time.
- R6: Pointer mode 01 adds 1 to the pointer after each unit, mode 10 subtracts 1, and modes 00 and 11 keep the pointer fixed.
- R7: Write-back stores word 0 with the new count and unchanged upper fields. It writes the source or destination word only when that pointer's mode is not fixed.
- R8: Counting from the first record read through the last cycle `bus_req` is high, a request takes 6 + 5×n cycles plus 1 for each non-fixed pointer, where n is the number of units moved.
- R9: When a request ends with a count of zero and `irq_en` is 1, `irq` is set. It stays set until a `sw_irq_clr` pulse. A zero count with `irq_en` at 0 leaves `irq` at 0.
- R10: `ch_on` is set by `sw_enable` and is cleared when a request ends with a zero count. While the count is nonzero the channel stays on for further requests.
- R11: A request that arrives while the channel holds the bus is latched. It is served by a new bus request after the current one is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Pulse: switch the channel on |
| sw_irq_clr | input | 1 | Pulse: clear the interrupt |
| irq_en | input | 1 | Raise interrupt when count reaches zero |
| desc_base | input | AW (16) | Word address of the three-word record |
| xfer_req | input | 1 | Transfer request pulse |
| xfer_ack | output | 1 | Data write in progress |
| xfer_end | output | 1 | Final-unit write in progress |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus granted |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (16) | Word address |
| mem_wdata | output | DW (32) | Write data |
| mem_rdata | input | DW (32) | Read data, valid one cycle after a read |
| ch_on | output | 1 | Channel enabled |
| irq | output | 1 | Sticky end-of-count interrupt |

## Verification
The assertions assume the following about the environment:
- The grant, once given, stays high until `bus_req` drops.
- Read data arrives exactly one cycle after a read strobe.
- `desc_base` does not change while the channel owns the bus.
- A record is never fetched with a count of zero.

The bench models the bus owner as a register that follows `bus_req` only when the test allows it. Its memory is a registered array with the one-cycle read delay. Every test rewrites the record and base address only while `bus_req` is low, and every loaded count is at least one.

// File: rtl/dma_blk_seq_pkg.sv
package dma_blk_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_REQ, ST_D0, ST_D1, ST_D2, ST_D3,
      ST_URD, ST_UCAP, ST_UWR, ST_UUPD, ST_UCHK,
      ST_WCNT, ST_WSRC, ST_WDST, ST_REL
   } seq_state_e;

   typedef enum logic [1:0] {
      PM_FIX0 = 2'b00,
      PM_INC  = 2'b01,
      PM_DEC  = 2'b10,
      PM_FIX1 = 2'b11
   } ptr_mode_e;

   function automatic logic mode_moves(input logic [1:0] m);
      return (m == PM_INC) || (m == PM_DEC);
   endfunction

endpackage

// File: rtl/dma_blk_seq_ptr.sv
module dma_blk_seq_ptr
   import dma_blk_seq_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  logic [1:0]    mode,
   output logic [AW-1:0] addr,
   output logic          moves
);

   assign moves = mode_moves(mode);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_val;
      end else if (step) begin
         case (mode)
            PM_INC:  addr <= addr + AW'(1);
            PM_DEC:  addr <= addr - AW'(1);
            default: addr <= addr;
         endcase
      end
   end

   // R6
   fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !moves) |=> $stable(addr));

   // R6
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step && mode == PM_INC) |=> (addr == $past(addr) + AW'(1)));

endmodule

// File: rtl/dma_blk_seq_flags.sv
module dma_blk_seq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_enable,
   input  logic sw_irq_clr,
   input  logic irq_en,
   input  logic xfer_req,
   input  logic accept,
   input  logic finish_zero,
   output logic ch_on,
   output logic pend,
   output logic irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch_on <= 1'b0;
         pend  <= 1'b0;
         irq   <= 1'b0;
      end else begin
         if (finish_zero)    ch_on <= 1'b0;
         else if (sw_enable) ch_on <= 1'b1;

         if (!ch_on)         pend <= 1'b0;
         else if (xfer_req)  pend <= 1'b1;
         else if (accept)    pend <= 1'b0;

         if (finish_zero && irq_en) irq <= 1'b1;
         else if (sw_irq_clr)       irq <= 1'b0;
      end
   end

   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !sw_irq_clr) |=> irq);

   // R1
   pend_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_on |=> !pend);

   // R10
   off_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish_zero |=> !ch_on);

endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
   import dma_blk_seq_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int CNT_W = 16,
   parameter int BLK_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_enable,
   input  logic          sw_irq_clr,
   input  logic          irq_en,
   input  logic [AW-1:0] desc_base,
   input  logic          xfer_req,
   output logic          xfer_ack,
   output logic          xfer_end,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          ch_on,
   output logic          irq
);

   localparam int BLK_LSB = CNT_W;
   localparam int SM_LSB  = BLK_LSB + BLK_W;
   localparam int DM_LSB  = SM_LSB + 2;
   localparam int CTRL_W  = DW - CNT_W;
   localparam int UNIT_W  = BLK_W + 1;

   if (DM_LSB + 2 > DW) begin : g_bad_fields
      $error("dma_blk_seq: record fields do not fit in DW");
   end
   if (AW >= DW) begin : g_bad_aw
      $error("dma_blk_seq: AW must be narrower than DW");
   end

   seq_state_e        st_q, st_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DW-1:0]     data_q;
   logic [UNIT_W-1:0] units_q;
   logic              pend, accept, finish_zero, blk_done;
   logic [1:0]        mode_w   [2];
   logic [AW-1:0]     ptr_addr [2];
   logic              ptr_mv   [2];
   logic [BLK_W-1:0]  blk_w;

   assign blk_w     = ctrl_q[BLK_W-1:0];
   assign mode_w[0] = ctrl_q[SM_LSB-CNT_W +: 2];
   assign mode_w[1] = ctrl_q[DM_LSB-CNT_W +: 2];
   assign blk_done  = (cnt_q == '0) || (units_q >= {1'b0, blk_w});

   for (genvar g = 0; g < 2; g++) begin : g_ptr
      dma_blk_seq_ptr #(.AW(AW)) u_ptr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (st_q == ((g == 0) ? ST_D2 : ST_D3)),
         .load_val (mem_rdata[AW-1:0]),
         .step     (st_q == ST_UUPD),
         .mode     (mode_w[g]),
         .addr     (ptr_addr[g]),
         .moves    (ptr_mv[g])
      );
   end

   assign accept      = (st_q == ST_REQ) && bus_gnt;
   assign finish_zero = (st_q == ST_REL) && (cnt_q == '0);

   dma_blk_seq_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_enable   (sw_enable),
      .sw_irq_clr  (sw_irq_clr),
      .irq_en      (irq_en),
      .xfer_req    (xfer_req),
      .accept      (accept),
      .finish_zero (finish_zero),
      .ch_on       (ch_on),
      .pend        (pend),
      .irq         (irq)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (ch_on && pend) st_d = ST_REQ;
         ST_REQ:  if (bus_gnt) st_d = ST_D0;
         ST_D0:   st_d = ST_D1;
         ST_D1:   st_d = ST_D2;
         ST_D2:   st_d = ST_D3;
         ST_D3:   st_d = ST_URD;
         ST_URD:  st_d = ST_UCAP;
         ST_UCAP: st_d = ST_UWR;
         ST_UWR:  st_d = ST_UUPD;
         ST_UUPD: st_d = ST_UCHK;
         ST_UCHK: st_d = blk_done ? ST_WCNT : ST_URD;
         ST_WCNT: st_d = ptr_mv[0] ? ST_WSRC : (ptr_mv[1] ? ST_WDST : ST_REL);
         ST_WSRC: st_d = ptr_mv[1] ? ST_WDST : ST_REL;
         ST_WDST: st_d = ST_REL;
         ST_REL:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         ctrl_q  <= '0;
         data_q  <= '0;
         units_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_D0) units_q <= '0;
         if (st_q == ST_D1) begin
            cnt_q  <= mem_rdata[CNT_W-1:0];
            ctrl_q <= mem_rdata[DW-1:CNT_W];
         end
         if (st_q == ST_UCAP) data_q <= mem_rdata;
         if (st_q == ST_UUPD) begin
            cnt_q   <= cnt_q - CNT_W'(1);
            units_q <= units_q + UNIT_W'(1);
         end
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st_q)
         ST_D0:   begin mem_en = 1'b1; mem_addr = desc_base; end
         ST_D1:   begin mem_en = 1'b1; mem_addr = desc_base + AW'(1); end
         ST_D2:   begin mem_en = 1'b1; mem_addr = desc_base + AW'(2); end
         ST_URD:  begin mem_en = 1'b1; mem_addr = ptr_addr[0]; end
         ST_UWR:  begin
            mem_en = 1'b1; mem_we = 1'b1;
            mem_addr = ptr_addr[1]; mem_wdata = data_q;
         end
         ST_WCNT: begin
            mem_en = 1'b1; mem_we = 1'b1;
            mem_addr = desc_base; mem_wdata = {ctrl_q, cnt_q};
         end
         ST_WSRC: begin
            mem_en = 1'b1; mem_we = 1'b1;
            mem_addr = desc_base + AW'(1);
            mem_wdata = {{(DW-AW){1'b0}}, ptr_addr[0]};
         end
         ST_WDST: begin
            mem_en = 1'b1; mem_we = 1'b1;
            mem_addr = desc_base + AW'(2);
            mem_wdata = {{(DW-AW){1'b0}}, ptr_addr[1]};
         end
         default: ;
      endcase
   end

   assign bus_req  = (st_q != ST_IDLE);
   assign xfer_ack = (st_q == ST_UWR);
   assign xfer_end = (st_q == ST_UWR) && (cnt_q == CNT_W'(1));

   // R2
   no_bus_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> !mem_en);

   // R2
   req_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !mem_en);

   // R5
   end_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |-> xfer_ack);

   // R5
   ack_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |-> (mem_en && mem_we && mem_addr == ptr_addr[1]));

   // R4
   units_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_URD) |-> (units_q == '0 || units_q < {1'b0, blk_w}));

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_UUPD) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: tb/dma_blk_seq_bench.sv
`timescale 1ns/1ps
module dma_blk_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_enable = 1'b0, sw_irq_clr = 1'b0, irq_en = 1'b0;
   logic [15:0] desc_base = '0;
   logic        xfer_req = 1'b0;
   logic        xfer_ack, xfer_end, bus_req;
   logic        bus_gnt = 1'b0;
   logic        mem_en, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] rd_q = '0;
   logic        ch_on, irq;
   logic        gnt_allow = 1'b1;
   logic [31:0] mem [128];

   int checks = 0, fails = 0;
   int n_ack = 0, n_end = 0, n_memen = 0, n_wb1 = 0, n_wb2 = 0;
   int hold_cnt = 0, last_hold = 0, holds_done = 0;
   bit in_hold = 0;
   logic [15:0] rd_log [3];

   always #4 clk = ~clk;

   dma_blk_seq u_dma_blk_seq (
      .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .sw_irq_clr(sw_irq_clr),
      .irq_en(irq_en), .desc_base(desc_base), .xfer_req(xfer_req),
      .xfer_ack(xfer_ack), .xfer_end(xfer_end), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(rd_q), .ch_on(ch_on), .irq(irq)
   );

   always @(posedge clk) begin
      bus_gnt <= gnt_allow && bus_req;
      if (mem_en) begin
         if (mem_we) mem[mem_addr[6:0]] <= mem_wdata;
         else        rd_q <= mem[mem_addr[6:0]];
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (xfer_ack) n_ack++;
         if (xfer_end) n_end++;
         if (mem_en) n_memen++;
         if (mem_en && mem_we && mem_addr == desc_base + 16'd1) n_wb1++;
         if (mem_en && mem_we && mem_addr == desc_base + 16'd2) n_wb2++;
         if (bus_req && (in_hold || mem_en)) begin
            if (hold_cnt < 3) rd_log[hold_cnt] = mem_addr;
            in_hold = 1;
            hold_cnt++;
         end else if (in_hold && !bus_req) begin
            last_hold = hold_cnt;
            hold_cnt = 0;
            in_hold = 0;
            holds_done++;
         end
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_req();
      xfer_req = 1'b1; tick(); xfer_req = 1'b0;
   endtask

   task automatic pulse_en();
      sw_enable = 1'b1; tick(); sw_enable = 1'b0;
   endtask

   task automatic wait_holds(input int target);
      while (holds_done < target) tick();
   endtask

   function automatic logic [31:0] mk_w0(input int cnt, input int blk, input int sm, input int dm);
      return {4'h0, dm[1:0], sm[1:0], blk[7:0], cnt[15:0]};
   endfunction

   task automatic t_reset();
      chk(bus_req == 0 && mem_en == 0, "R1 reset bus", bus_req, 0);
      chk(irq == 0 && ch_on == 0, "R1 reset flags", {irq, ch_on}, 0);
      pulse_req();
      tick(8);
      chk(bus_req == 0 && holds_done == 0, "R1 request while off", bus_req, 0);
   endtask

   task automatic t_block_inc();
      int a0, h0;
      desc_base = 16'h0000; irq_en = 1'b0;
      mem[0] = mk_w0(10, 4, 1, 1); mem[1] = 32'h20; mem[2] = 32'h30;
      for (int i = 0; i < 8; i++) begin mem[32 + i] = 32'hA0 + i; mem[48 + i] = 0; end
      a0 = n_ack; h0 = holds_done;
      pulse_en();
      pulse_req();
      while (n_ack == a0) tick();
      pulse_req();
      wait_holds(h0 + 1);
      chk(rd_log[0] == 0 && rd_log[1] == 1 && rd_log[2] == 2, "R3 record reads",
          {rd_log[0], rd_log[1], rd_log[2]}, 48'h000000010002);
      chk(last_hold == 28, "R8 both update", last_hold, 28);
      chk(mem[0] == mk_w0(6, 4, 1, 1), "R7 count wb", mem[0], mk_w0(6, 4, 1, 1));
      chk(mem[1] == 32'h24 && mem[2] == 32'h34, "R6 increment wb", {mem[1], mem[2]}, 64'h0000002400000034);
      wait_holds(h0 + 2);
      chk(holds_done == h0 + 2, "R11 latched request served", holds_done, h0 + 2);
      chk(mem[0] == mk_w0(2, 4, 1, 1) && mem[1] == 32'h28 && mem[2] == 32'h38,
          "R11 second record", mem[0], mk_w0(2, 4, 1, 1));
      for (int i = 0; i < 8; i++)
         chk(mem[48 + i] == 32'hA0 + i, "R4 data copy", mem[48 + i], 32'hA0 + i);
      chk(n_ack - a0 == 8, "R5 ack per write", n_ack - a0, 8);
      chk(n_end == 0, "R5 no end while count left", n_end, 0);
      chk(ch_on == 1 && irq == 0, "R10 stays on", {ch_on, irq}, 2'b10);
   endtask

   task automatic t_fixed_dec();
      int a0, e0, w1, h0;
      desc_base = 16'h0008; irq_en = 1'b1;
      mem[8] = mk_w0(3, 5, 0, 2); mem[9] = 32'h40; mem[10] = 32'h4C;
      mem[64] = 32'h55; mem[73] = 32'h77;
      for (int i = 74; i < 77; i++) mem[i] = 0;
      a0 = n_ack; e0 = n_end; w1 = n_wb1; h0 = holds_done;
      pulse_en();
      pulse_req();
      wait_holds(h0 + 1);
      chk(last_hold == 22, "R8 one update", last_hold, 22);
      chk(n_ack - a0 == 3, "R4 count limits block", n_ack - a0, 3);
      chk(n_end - e0 == 1, "R5 one end pulse", n_end - e0, 1);
      chk(mem[74] == 32'h55 && mem[75] == 32'h55 && mem[76] == 32'h55,
          "R6 fixed source dec dest", mem[74], 32'h55);
      chk(mem[73] == 32'h77, "R6 dest stops", mem[73], 32'h77);
      chk(mem[10] == 32'h49, "R6 decrement wb", mem[10], 32'h49);
      chk(mem[8] == mk_w0(0, 5, 0, 2), "R7 zero count wb", mem[8], mk_w0(0, 5, 0, 2));
      chk(n_wb1 == w1, "R7 fixed source not written", n_wb1 - w1, 0);
      chk(irq == 1, "R9 irq raised", irq, 1);
      chk(ch_on == 0, "R10 auto off", ch_on, 0);
      pulse_req();
      tick(8);
      chk(bus_req == 0 && holds_done == h0 + 1, "R1 off ignores request", bus_req, 0);
      chk(irq == 1, "R9 irq sticky", irq, 1);
      sw_irq_clr = 1'b1; tick(); sw_irq_clr = 1'b0; tick();
      chk(irq == 0, "R9 irq cleared", irq, 0);
   endtask

   task automatic t_fixed_wait();
      int m0, a0, e0, w1, w2, h0;
      desc_base = 16'h0010; irq_en = 1'b1;
      mem[16] = mk_w0(2, 0, 3, 0); mem[17] = 32'h41; mem[18] = 32'h50;
      mem[65] = 32'h66; mem[80] = 0;
      gnt_allow = 1'b0;
      h0 = holds_done; w1 = n_wb1; w2 = n_wb2; a0 = n_ack; e0 = n_end;
      pulse_en();
      m0 = n_memen;
      pulse_req();
      tick(10);
      chk(bus_req == 1, "R2 request raised", bus_req, 1);
      chk(n_memen == m0, "R2 no access before grant", n_memen - m0, 0);
      gnt_allow = 1'b1;
      wait_holds(h0 + 1);
      chk(last_hold == 11, "R8 both fixed", last_hold, 11);
      chk(n_ack - a0 == 1, "R4 block zero moves one", n_ack - a0, 1);
      chk(mem[80] == 32'h66, "R4 fixed copy", mem[80], 32'h66);
      chk(mem[16] == mk_w0(1, 0, 3, 0), "R7 count wb fixed", mem[16], mk_w0(1, 0, 3, 0));
      chk(n_wb1 == w1 && n_wb2 == w2, "R7 no pointer wb", (n_wb1 - w1) + (n_wb2 - w2), 0);
      chk(irq == 0 && ch_on == 1, "R9 no irq with count left", {irq, ch_on}, 2'b01);
      irq_en = 1'b0;
      pulse_req();
      wait_holds(h0 + 2);
      chk(mem[16] == mk_w0(0, 0, 3, 0), "R4 second unit", mem[16], mk_w0(0, 0, 3, 0));
      chk(n_end - e0 == 1, "R5 end on last", n_end - e0, 1);
      chk(irq == 0, "R9 disabled irq", irq, 0);
      chk(ch_on == 0, "R10 off at zero", ch_on, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = '0;
      tick(4);
      t_reset_pre();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_block_inc();
      t_fixed_dec();
      t_fixed_wait();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic t_reset_pre();
      chk(bus_req == 0 && irq == 0 && ch_on == 0, "R1 in reset", {bus_req, irq, ch_on}, 0);
   endtask

endmodule